// File: doc/BRIEF.md
# Seconds Counter Real-Time Clock with Match Alarm

This block is a memory-mapped real-time clock that sits on a simple 32-bit register bus with select, enable and write strobes. It keeps a seconds count that steps once for every `TICK_DIV` pulses of a reference enable, and with the default divider of 32768 a 32768 Hz reference gives one step per second. Software sets the count through a load register, reads it back from a data register and programs a match value. When the count reaches the match value, a sticky alarm flag is raised.

Interrupt handling uses four registers. There is a raw flag, a mask, a masked view (raw AND mask) and a write-one-to-clear register. The interrupt pin is the OR of the masked bits, and here that is the single alarm bit. A control bit starts and stops the count. The register bus and the reference enable share one clock.

Top module: `rtc_seconds_alarm`

## Requirements
- R1: After reset every mapped register reads zero and `alarmIrq` is low.
- R2: Byte offsets, with word-aligned addresses: 0x00 reads the count and ignores writes; 0x04 is the 32-bit match value (read/write); 0x08 loads the count and reads back the last value written; 0x0C bit 0 is count enable and its other bits read zero; 0x10 bit 0 is the alarm mask; 0x14 bit 0 is the raw alarm; 0x18 bit 0 is the masked alarm; 0x1C is write-only and reads zero. A write takes effect at the rising edge where `busSel`, `busEnable` and `busWrite` are all high. Read data is combinational while `busSel` is high.
- R3: While the enable bit is 1, the count steps by one on every `TICK_DIV`-th clock that has `refEn` high. While the enable bit is 0, neither the count nor the prescaler moves.
- R4: A write to the load register sets the count at that edge and returns the prescaler to zero. A load takes priority over a tick in the same cycle.
- R5: The count wraps from 0xFFFFFFFF to 0.
- R6: The raw alarm sets at the edge where the count changes, by a tick or a load, to a value equal to the match register. It then stays set until it is cleared. Writing a match value equal to the current count does not set it.
- R7: Writing 1 to bit 0 of offset 0x1C clears the raw alarm. Writing 0 there has no effect.
- R8: When a clear and a new match happen at the same edge, the raw alarm ends up set.
- R9: The masked status equals raw AND mask, and `alarmIrq` equals the masked alarm bit.
- R10: Reads of unmapped or misaligned addresses return zero, and writes to them change nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock shared by the bus and the counter |
| rstN | input | 1 | Active-low synchronous reset |
| refEn | input | 1 | One-cycle pulse per reference period |
| busSel | input | 1 | Register bus select |
| busEnable | input | 1 | Register bus access phase |
| busWrite | input | 1 | 1 = write, 0 = read |
| busAddr | input | ADDR_W | Byte address |
| busWdata | input | DATA_W | Write data |
| busRdata | output | DATA_W | Read data, combinational |
| alarmIrq | output | 1 | Masked alarm interrupt |

## Verification
Register writes, loads, clears and counter steps all show up after the single rising edge that captures them. The raw alarm and `alarmIrq` change at the same edge as the count step or load that causes the match. Read data follows the address with no delay. For these reasons the bench drives inputs on the falling edge and reads 2 ns later. It runs the reference enable for an exact number of rising edges, so the expected count is the starting value plus the number of ticks divided by the divider. To test the priority of a match over a clear, the bench forces both onto the same rising edge.

// File: rtl/rtc_alarm_pkg.sv
`timescale 1ns/1ps
package rtc_alarm_pkg;
  // register slot indices; byte offset = 4 * index
  localparam int NUM_REGS  = 8;
  localparam int IDX_DATA  = 0;
  localparam int IDX_MATCH = 1;
  localparam int IDX_LOAD  = 2;
  localparam int IDX_CTRL  = 3;
  localparam int IDX_MASK  = 4;
  localparam int IDX_RAW   = 5;
  localparam int IDX_MSKD  = 6;
  localparam int IDX_CLR   = 7;

  typedef struct packed {
    logic loadCnt;
    logic wrMatch;
    logic wrCtrl;
    logic wrMask;
    logic clrAlarm;
  } rtcStrobes_t;
endpackage

// File: rtl/rtc_alarm_ctrl.sv
`timescale 1ns/1ps
module rtc_alarm_ctrl
  import rtc_alarm_pkg::*;
#(
  parameter int ADDR_W = 8,
  parameter int DATA_W = 32
) (
  input  logic              busSel,
  input  logic              busEnable,
  input  logic              busWrite,
  input  logic [ADDR_W-1:0] busAddr,
  input  logic              clrBit,
  input  logic [DATA_W-1:0] cntValue,
  input  logic [DATA_W-1:0] matchValue,
  input  logic [DATA_W-1:0] loadValue,
  input  logic              ctrlEn,
  input  logic              maskEn,
  input  logic              rawFlag,
  output rtcStrobes_t       stb,
  output logic [DATA_W-1:0] busRdata
);
  logic [NUM_REGS-1:0] hit;
  logic                wrPhase;
  logic [DATA_W-1:0]   rdData;

  genvar gi;
  generate
    for (gi = 0; gi < NUM_REGS; gi++) begin : g_dec
      assign hit[gi] = (busAddr == ADDR_W'(gi * 4));
    end
  endgenerate

  assign wrPhase = busSel & busEnable & busWrite;

  always_comb begin
    stb          = '0;
    stb.wrMatch  = wrPhase & hit[IDX_MATCH];
    stb.loadCnt  = wrPhase & hit[IDX_LOAD];
    stb.wrCtrl   = wrPhase & hit[IDX_CTRL];
    stb.wrMask   = wrPhase & hit[IDX_MASK];
    stb.clrAlarm = wrPhase & hit[IDX_CLR] & clrBit;
  end

  always_comb begin
    rdData = '0;
    if (hit[IDX_DATA])  rdData = cntValue;
    if (hit[IDX_MATCH]) rdData = matchValue;
    if (hit[IDX_LOAD])  rdData = loadValue;
    if (hit[IDX_CTRL])  rdData[0] = ctrlEn;
    if (hit[IDX_MASK])  rdData[0] = maskEn;
    if (hit[IDX_RAW])   rdData[0] = rawFlag;
    if (hit[IDX_MSKD])  rdData[0] = rawFlag & maskEn;
  end

  assign busRdata = busSel ? rdData : '0;
endmodule

// File: rtl/rtc_alarm_dp.sv
`timescale 1ns/1ps
module rtc_alarm_dp
  import rtc_alarm_pkg::*;
#(
  parameter int DATA_W   = 32,
  parameter int TICK_DIV = 32768
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              refEn,
  input  rtcStrobes_t       stb,
  input  logic [DATA_W-1:0] wdata,
  output logic [DATA_W-1:0] cntValue,
  output logic [DATA_W-1:0] matchValue,
  output logic [DATA_W-1:0] loadValue,
  output logic              ctrlEn,
  output logic              maskEn,
  output logic              rawFlag,
  output logic              alarmIrq
);
  localparam int PRESC_W = (TICK_DIV > 1) ? $clog2(TICK_DIV) : 1;
  localparam logic [PRESC_W-1:0] PRESC_LAST = PRESC_W'(TICK_DIV - 1);

  logic [PRESC_W-1:0] presc, prescNext;
  logic [DATA_W-1:0]  cntNext;
  logic               tickDue, cntMoves, hitNow;

  assign tickDue = ctrlEn & refEn & (presc == PRESC_LAST);

  always_comb begin
    if (stb.loadCnt)           prescNext = '0;
    else if (ctrlEn && refEn)  prescNext = tickDue ? '0 : presc + 1'b1;
    else                       prescNext = presc;
  end

  always_comb begin
    if (stb.loadCnt)   cntNext = wdata;
    else if (tickDue)  cntNext = cntValue + 1'b1;
    else               cntNext = cntValue;
  end

  assign cntMoves = stb.loadCnt | tickDue;
  // compare against the match value held before any same-edge rewrite
  assign hitNow   = cntMoves & (cntNext == matchValue);

  always_ff @(posedge clk) begin
    if (!rstN) begin
      presc      <= '0;
      cntValue   <= '0;
      matchValue <= '0;
      loadValue  <= '0;
      ctrlEn     <= 1'b0;
      maskEn     <= 1'b0;
      rawFlag    <= 1'b0;
    end else begin
      presc    <= prescNext;
      cntValue <= cntNext;
      if (stb.wrMatch) matchValue <= wdata;
      if (stb.loadCnt) loadValue  <= wdata;
      if (stb.wrCtrl)  ctrlEn     <= wdata[0];
      if (stb.wrMask)  maskEn     <= wdata[0];
      if (hitNow)             rawFlag <= 1'b1;
      else if (stb.clrAlarm)  rawFlag <= 1'b0;
    end
  end

  assign alarmIrq = rawFlag & maskEn;
endmodule

// File: rtl/rtc_seconds_alarm.sv
`timescale 1ns/1ps
module rtc_seconds_alarm
  import rtc_alarm_pkg::*;
#(
  parameter int ADDR_W   = 8,
  parameter int DATA_W   = 32,
  parameter int TICK_DIV = 32768
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              refEn,
  input  logic              busSel,
  input  logic              busEnable,
  input  logic              busWrite,
  input  logic [ADDR_W-1:0] busAddr,
  input  logic [DATA_W-1:0] busWdata,
  output logic [DATA_W-1:0] busRdata,
  output logic              alarmIrq
);
  rtcStrobes_t       stb;
  logic [DATA_W-1:0] cntValue, matchValue, loadValue;
  logic              ctrlEn, maskEn, rawFlag;

  rtc_alarm_ctrl #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_ctrl (
    .busSel(busSel), .busEnable(busEnable), .busWrite(busWrite),
    .busAddr(busAddr), .clrBit(busWdata[0]),
    .cntValue(cntValue), .matchValue(matchValue), .loadValue(loadValue),
    .ctrlEn(ctrlEn), .maskEn(maskEn), .rawFlag(rawFlag),
    .stb(stb), .busRdata(busRdata)
  );

  rtc_alarm_dp #(.DATA_W(DATA_W), .TICK_DIV(TICK_DIV)) u_dp (
    .clk(clk), .rstN(rstN), .refEn(refEn), .stb(stb), .wdata(busWdata),
    .cntValue(cntValue), .matchValue(matchValue), .loadValue(loadValue),
    .ctrlEn(ctrlEn), .maskEn(maskEn), .rawFlag(rawFlag), .alarmIrq(alarmIrq)
  );
endmodule

// File: rtl/rtc_alarm_chk.sv
`timescale 1ns/1ps
module rtc_alarm_chk
  import rtc_alarm_pkg::*;
#(
  parameter int ADDR_W = 8,
  parameter int DATA_W = 32
) (
  input logic              clk,
  input logic              rstN,
  input logic              busSel,
  input logic [ADDR_W-1:0] busAddr,
  input logic [DATA_W-1:0] busWdata,
  input logic [DATA_W-1:0] busRdata,
  input logic              alarmIrq,
  input rtcStrobes_t       stb,
  input logic [DATA_W-1:0] cntValue,
  input logic [DATA_W-1:0] matchValue,
  input logic              ctrlEn,
  input logic              rawFlag
);
  logic unmapped;
  assign unmapped = (busAddr[1:0] != 2'b00) || (busAddr > ADDR_W'(4 * (NUM_REGS - 1)));

  // R3
  disabled_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    (!ctrlEn && !stb.loadCnt) |=> (cntValue == $past(cntValue)));

  // R4
  load_value_chk: assert property (@(posedge clk) disable iff (!rstN)
    stb.loadCnt |=> (cntValue == $past(busWdata)));

  // R5
  step_size_chk: assert property (@(posedge clk) disable iff (!rstN)
    !stb.loadCnt |=> (cntValue == $past(cntValue) || cntValue == $past(cntValue) + 1'b1));

  // R6
  rise_on_match_chk: assert property (@(posedge clk) disable iff (!rstN)
    ($rose(rawFlag) && !$past(stb.wrMatch)) |-> (cntValue == matchValue));

  // R6
  sticky_raw_chk: assert property (@(posedge clk) disable iff (!rstN)
    (rawFlag && !stb.clrAlarm) |=> rawFlag);

  // R9
  masked_view_chk: assert property (@(posedge clk) disable iff (!rstN)
    (busSel && busAddr == ADDR_W'(4 * IDX_MSKD)) |-> (busRdata[0] == alarmIrq));

  // R10
  unmapped_zero_chk: assert property (@(posedge clk) disable iff (!rstN)
    (busSel && unmapped) |-> (busRdata == '0));
endmodule

bind rtc_seconds_alarm rtc_alarm_chk #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_chk (
  .clk(clk), .rstN(rstN), .busSel(busSel), .busAddr(busAddr),
  .busWdata(busWdata), .busRdata(busRdata), .alarmIrq(alarmIrq),
  .stb(stb), .cntValue(cntValue), .matchValue(matchValue),
  .ctrlEn(ctrlEn), .rawFlag(rawFlag)
);

// File: tb/rtc_seconds_alarm_bench.sv
`timescale 1ns/1ps
module rtc_seconds_alarm_bench;
  localparam int DIV = 4;
  localparam logic [7:0] A_DATA = 8'h00, A_MATCH = 8'h04, A_LOAD = 8'h08,
    A_CTRL = 8'h0C, A_MASK = 8'h10, A_RAW = 8'h14, A_MSKD = 8'h18, A_CLR = 8'h1C;

  typedef struct packed {
    logic [31:0] loadVal;
    logic [31:0] matchVal;
    logic [15:0] ticks;
    logic [31:0] expCnt;
    logic        expRaw;
  } vec_t;

  localparam vec_t [0:5] VECS = '{
    '{32'd100,        32'd103,        16'd12, 32'd103,        1'b1},
    '{32'd100,        32'd200,        16'd12, 32'd103,        1'b0},
    '{32'hFFFF_FFFE,  32'd0,          16'd8,  32'd0,          1'b1},
    '{32'd55,         32'd55,         16'd0,  32'd55,         1'b1},
    '{32'd7,          32'd9,          16'd7,  32'd8,          1'b0},
    '{32'h1234_5678,  32'h1234_5679,  16'd3,  32'h1234_5678,  1'b0}
  };

  logic        clk = 1'b0, rstN = 1'b0, refEn = 1'b0;
  logic        busSel = 1'b0, busEnable = 1'b0, busWrite = 1'b0;
  logic [7:0]  busAddr = '0;
  logic [31:0] busWdata = '0, busRdata, rd;
  logic        alarmIrq;
  int          nChecks = 0, nFails = 0;
  bit          finished = 1'b0;

  always #10 clk = ~clk;

  rtc_seconds_alarm #(.ADDR_W(8), .DATA_W(32), .TICK_DIV(DIV)) u_rtc_seconds_alarm (
    .clk(clk), .rstN(rstN), .refEn(refEn), .busSel(busSel), .busEnable(busEnable),
    .busWrite(busWrite), .busAddr(busAddr), .busWdata(busWdata),
    .busRdata(busRdata), .alarmIrq(alarmIrq)
  );

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    nChecks++;
    if (act !== exp) begin
      nFails++;
      $display("FAIL %s: got %h expected %h", tag, act, exp);
    end
  endtask

  task automatic regWrite(input logic [7:0] a, input logic [31:0] d);
    @(negedge clk);
    busSel = 1'b1; busWrite = 1'b1; busEnable = 1'b0; busAddr = a; busWdata = d;
    @(negedge clk);
    busEnable = 1'b1;
    @(negedge clk);
    busSel = 1'b0; busEnable = 1'b0; busWrite = 1'b0;
  endtask

  task automatic regRead(input logic [7:0] a, output logic [31:0] d);
    @(negedge clk);
    busSel = 1'b1; busWrite = 1'b0; busAddr = a;
    #2 d = busRdata;
    busSel = 1'b0;
  endtask

  task automatic tickRef(input int n);
    if (n > 0) begin
      @(negedge clk);
      refEn = 1'b1;
      repeat (n) @(negedge clk);
      refEn = 1'b0;
    end
  endtask

  initial begin
    #(20 * 150000);
    if (!finished) begin
      nChecks++; nFails++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("%0d/%0d checks passed", nChecks - nFails, nChecks);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1'b1;

    // R1 reset state of every register
    for (int i = 0; i < 8; i++) begin
      regRead(8'(i * 4), rd);
      check("R1 reset read", rd, 32'd0);
    end
    check("R1 irq after reset", {31'd0, alarmIrq}, 32'd0);

    regWrite(A_MASK, 32'd1);
    regWrite(A_CTRL, 32'd1);

    // table walk: R3 R4 R5 R6 R9
    for (int v = 0; v < 6; v++) begin
      regWrite(A_CLR, 32'd1);
      regWrite(A_MATCH, VECS[v].matchVal);
      regWrite(A_LOAD, VECS[v].loadVal);
      tickRef(int'(VECS[v].ticks));
      regRead(A_DATA, rd);
      check($sformatf("R3/R5 vec%0d count", v), rd, VECS[v].expCnt);
      regRead(A_RAW, rd);
      check($sformatf("R6 vec%0d raw", v), rd, {31'd0, VECS[v].expRaw});
      check($sformatf("R9 vec%0d irq", v), {31'd0, alarmIrq}, {31'd0, VECS[v].expRaw});
    end

    // R8: prescaler sits at 3, count 0x12345678, match 0x12345679
    @(negedge clk);
    busSel = 1'b1; busWrite = 1'b1; busEnable = 1'b1; busAddr = A_CLR; busWdata = 32'd1;
    refEn = 1'b1;
    @(negedge clk);
    busSel = 1'b0; busWrite = 1'b0; busEnable = 1'b0; refEn = 1'b0;
    regRead(A_DATA, rd);
    check("R8 count at hit", rd, 32'h1234_5679);
    regRead(A_RAW, rd);
    check("R8 set beats clear", rd, 32'd1);

    // R6 sticky across further ticks
    tickRef(8);
    regRead(A_RAW, rd);
    check("R6 sticky raw", rd, 32'd1);

    // R9 mask off
    regWrite(A_MASK, 32'd0);
    regRead(A_MSKD, rd);
    check("R9 masked view off", rd, 32'd0);
    check("R9 irq masked", {31'd0, alarmIrq}, 32'd0);
    regRead(A_RAW, rd);
    check("R9 raw under mask", rd, 32'd1);

    // R7 clear semantics
    regWrite(A_CLR, 32'd0);
    regRead(A_RAW, rd);
    check("R7 zero write keeps raw", rd, 32'd1);
    regWrite(A_CLR, 32'd1);
    regRead(A_RAW, rd);
    check("R7 one write clears", rd, 32'd0);
    regWrite(A_MASK, 32'd1);

    // R6 match written equal to current count
    regWrite(A_MATCH, 32'h1234_567B);
    regRead(A_RAW, rd);
    check("R6 match equal to count", rd, 32'd0);

    // R3 disable, R2 control readback
    regWrite(A_CTRL, 32'hFFFF_FFFE);
    regRead(A_CTRL, rd);
    check("R2 ctrl bit0 only (0)", rd, 32'd0);
    tickRef(20);
    regRead(A_DATA, rd);
    check("R3 disabled holds", rd, 32'h1234_567B);
    regWrite(A_CTRL, 32'hFFFF_FFFF);
    regRead(A_CTRL, rd);
    check("R2 ctrl bit0 only (1)", rd, 32'd1);
    regWrite(A_MASK, 32'hFFFF_FFFF);
    regRead(A_MASK, rd);
    check("R2 mask bit0 only", rd, 32'd1);

    // R4 prescaler restart on load
    regWrite(A_LOAD, 32'd1000);
    tickRef(3);
    regWrite(A_LOAD, 32'd2000);
    tickRef(3);
    regRead(A_DATA, rd);
    check("R4 prescaler restarted", rd, 32'd2000);
    tickRef(1);
    regRead(A_DATA, rd);
    check("R4 step after full period", rd, 32'd2001);
    regRead(A_LOAD, rd);
    check("R2 load readback", rd, 32'd2000);

    // R2 data register ignores writes
    regWrite(A_DATA, 32'h5555_5555);
    regRead(A_DATA, rd);
    check("R2 data write ignored", rd, 32'd2001);
    regRead(A_CLR, rd);
    check("R2 clear reads zero", rd, 32'd0);

    // R10 unmapped and misaligned
    regWrite(8'h20, 32'hDEAD_BEEF);
    regWrite(8'h05, 32'hFFFF_FFFF);
    regRead(8'h20, rd);
    check("R10 unmapped read", rd, 32'd0);
    regRead(8'h05, rd);
    check("R10 misaligned read", rd, 32'd0);
    regRead(A_MATCH, rd);
    check("R10 match untouched", rd, 32'h1234_567B);
    regRead(A_RAW, rd);
    check("R10 raw untouched", rd, 32'd0);

    finished = 1'b1;
    $display("%0d/%0d checks passed", nChecks - nFails, nChecks);
    $finish;
  end
endmodule